// File: doc/BRIEF.md
# Serial Divider Configuration Loader

The block receives configuration for a frequency synthesizer's two dividers over three wires: a serial clock, a serial data line and a latch strobe. Each bit on the data line is taken on a rising edge of the serial clock and moves into a 19-stage chain. The chain holds an 18-bit data word and, in its last stage, a single select bit. The select bit is the final bit sent.

When the latch strobe rises, the select bit picks which register takes the word. The first choice is a 14-bit reference divide register, which takes only the low bits of the word. The second is an 18-bit main register that splits the word into a 6-bit swallow count and a 12-bit programmable count. In the same system-clock cycle that a register takes its new value, the block raises a one-cycle load pulse for that register.

All three serial inputs are asynchronous to the system clock. Each one passes through a two-flop synchronizer before any edge is detected. The dividers, the phase comparator and the charge pump are outside this block.

Top module: `serial_div_loader`

## Requirements
- R1: While reset is asserted (rstN low), the reference value, the swallow count and the programmable count all read zero, and both load pulses are low.
- R2: Each rising edge of serClk, once synchronized, shifts the synchronized serData bit into the chain. Bits arrive MSB first: 18 data bits (bit 17 first), then the select bit last.
- R3: A latch strobe rising edge with select bit 1 copies data bits 13..0 into refDiv. Data bits 17..14 are ignored.
- R4: A latch strobe rising edge with select bit 0 copies data bits 17..6 into mainCnt (N) and data bits 5..0 into swallowCnt (A).
- R5: A load into either register leaves the other register unchanged.
- R6: Serial clock activity while serLe stays low changes no output and raises no load pulse.
- R7: Each rising edge of serLe gives exactly one system-clock pulse, on refLoad (select 1) or on mainLoad (select 0), never on both. Holding serLe high gives no further pulses.
- R8: A new register value and its load pulse appear together, on the third rising system-clock edge after the serLe rising edge is present at the pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| serClk | input | 1 | Serial shift clock, asynchronous |
| serData | input | 1 | Serial data, MSB first |
| serLe | input | 1 | Latch strobe, acts on its rising edge |
| refDiv | output | 14 | Reference divide value |
| swallowCnt | output | 6 | Swallow count A |
| mainCnt | output | 12 | Programmable count N |
| refLoad | output | 1 | One-cycle pulse when refDiv is loaded |
| mainLoad | output | 1 | One-cycle pulse when swallowCnt/mainCnt are loaded |

## Verification
Each serial input crosses two synchronizer flops and one edge-detect register. The result of an input change is therefore due on the third rising system-clock edge after the change is sampled. The bench model keeps a four-deep history of the sampled pins and acts on the entries two and three edges old. It compares every output at each falling edge, half a period after the edge on which the design updates. Directed checks after each transfer wait well beyond that three-edge latency before reading the registers.

// File: rtl/sdl_pkg.sv
package sdl_pkg;
  typedef struct packed {
    logic shiftEn;
    logic loadRef;
    logic loadMain;
  } sdl_strobes_t;
endpackage

// File: rtl/sdl_sync.sv
module sdl_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] asyncIn,
  output logic [W-1:0] syncOut
);
  logic [W-1:0] stage [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) stage[s] <= '0;
        else if (s == 0) stage[s] <= asyncIn;
        else stage[s] <= stage[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign syncOut = stage[STAGES-1];
endmodule

// File: rtl/sdl_ctrl.sv
module sdl_ctrl
  import sdl_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         sclkSync,
  input  logic         leSync,
  input  logic         selBit,
  output sdl_strobes_t strobes
);
  logic sclkPrev, lePrev;
  logic sclkRise, leRise;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclkPrev <= 1'b0;
      lePrev   <= 1'b0;
    end else begin
      sclkPrev <= sclkSync;
      lePrev   <= leSync;
    end
  end

  assign sclkRise = sclkSync & ~sclkPrev;
  assign leRise   = leSync & ~lePrev;

  always_comb begin
    strobes.shiftEn  = sclkRise;
    strobes.loadRef  = leRise & selBit;
    strobes.loadMain = leRise & ~selBit;
  end

  // R2
  shift_once_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.shiftEn |=> !strobes.shiftEn);
  // R7
  load_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(strobes.loadRef && strobes.loadMain));
endmodule

// File: rtl/sdl_datapath.sv
module sdl_datapath
  import sdl_pkg::*;
#(
  parameter int REF_W  = 14,
  parameter int SWAL_W = 6,
  parameter int MAIN_W = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  sdl_strobes_t      strobes,
  input  logic              dataBit,
  output logic              selBit,
  output logic [REF_W-1:0]  refDiv,
  output logic [SWAL_W-1:0] swallowCnt,
  output logic [MAIN_W-1:0] mainCnt,
  output logic              refLoad,
  output logic              mainLoad
);
  localparam int WORD_W  = SWAL_W + MAIN_W;
  localparam int CHAIN_W = WORD_W + 1;

  logic [CHAIN_W-1:0] chain;
  logic [WORD_W-1:0]  word;

  assign word   = chain[CHAIN_W-1:1];
  assign selBit = chain[0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) chain <= '0;
    else if (strobes.shiftEn) chain <= {chain[CHAIN_W-2:0], dataBit};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      refDiv     <= '0;
      swallowCnt <= '0;
      mainCnt    <= '0;
      refLoad    <= 1'b0;
      mainLoad   <= 1'b0;
    end else begin
      refLoad  <= strobes.loadRef;
      mainLoad <= strobes.loadMain;
      if (strobes.loadRef) refDiv <= word[REF_W-1:0];
      if (strobes.loadMain) begin
        mainCnt    <= word[WORD_W-1:SWAL_W];
        swallowCnt <= word[SWAL_W-1:0];
      end
    end
  end

  // R3
  ref_sel_chk: assert property (@(posedge clk) disable iff (!rstN)
    refLoad |-> $past(selBit));
  // R4
  main_sel_chk: assert property (@(posedge clk) disable iff (!rstN)
    mainLoad |-> !$past(selBit));
  // R5
  ref_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !refLoad |-> $stable(refDiv));
  // R5
  main_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !mainLoad |-> ($stable(mainCnt) && $stable(swallowCnt)));
  // R7
  pulse_width_chk: assert property (@(posedge clk) disable iff (!rstN)
    (refLoad || mainLoad) |=> !(refLoad || mainLoad));
endmodule

// File: rtl/serial_div_loader.sv
module serial_div_loader
  import sdl_pkg::*;
#(
  parameter int REF_W       = 14,
  parameter int SWAL_W      = 6,
  parameter int MAIN_W      = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              serClk,
  input  logic              serData,
  input  logic              serLe,
  output logic [REF_W-1:0]  refDiv,
  output logic [SWAL_W-1:0] swallowCnt,
  output logic [MAIN_W-1:0] mainCnt,
  output logic              refLoad,
  output logic              mainLoad
);
  logic [2:0]   pinSync;
  logic         selBit;
  sdl_strobes_t strobes;

  sdl_sync #(.W(3), .STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rstN(rstN),
    .asyncIn({serClk, serData, serLe}),
    .syncOut(pinSync)
  );

  sdl_ctrl ctrl_i (
    .clk(clk), .rstN(rstN),
    .sclkSync(pinSync[2]), .leSync(pinSync[0]),
    .selBit(selBit), .strobes(strobes)
  );

  sdl_datapath #(.REF_W(REF_W), .SWAL_W(SWAL_W), .MAIN_W(MAIN_W)) dp_i (
    .clk(clk), .rstN(rstN), .strobes(strobes), .dataBit(pinSync[1]),
    .selBit(selBit), .refDiv(refDiv), .swallowCnt(swallowCnt),
    .mainCnt(mainCnt), .refLoad(refLoad), .mainLoad(mainLoad)
  );
endmodule

// File: tb/serial_div_loader_tb_top.sv
module serial_div_loader_tb_top;
  logic clk = 0, rstN = 0;
  logic serClk = 0, serData = 0, serLe = 0;
  logic [13:0] refDiv;
  logic [5:0]  swallowCnt;
  logic [11:0] mainCnt;
  logic refLoad, mainLoad;
  int checks = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  serial_div_loader dut_i (
    .clk(clk), .rstN(rstN), .serClk(serClk), .serData(serData), .serLe(serLe),
    .refDiv(refDiv), .swallowCnt(swallowCnt), .mainCnt(mainCnt),
    .refLoad(refLoad), .mainLoad(mainLoad)
  );

  // Behavioural model: pin history, acting on samples two and three edges old
  logic [2:0] hist [$];
  logic [18:0] mChain;
  logic [13:0] mRef;
  logic [5:0]  mA;
  logic [11:0] mN;
  logic mRefP, mMainP;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hist = {3'b0, 3'b0, 3'b0, 3'b0};
      mChain = '0; mRef = '0; mA = '0; mN = '0; mRefP = 0; mMainP = 0;
    end else begin
      logic sRise, lRise;
      hist.push_front({serClk, serData, serLe});
      void'(hist.pop_back());
      sRise = hist[2][2] && !hist[3][2];
      lRise = hist[2][0] && !hist[3][0];
      mRefP = lRise && mChain[0];
      mMainP = lRise && !mChain[0];
      if (mRefP) mRef = mChain[14:1];
      if (mMainP) begin mN = mChain[18:7]; mA = mChain[6:1]; end
      if (sRise) mChain = {mChain[17:0], hist[2][1]};
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) if (rstN && !done) begin
    chk("R3 R8 refDiv", refDiv, mRef);
    chk("R4 R8 mainCnt", mainCnt, mN);
    chk("R4 R8 swallowCnt", swallowCnt, mA);
    chk("R7 R8 refLoad", refLoad, mRefP);
    chk("R7 R8 mainLoad", mainLoad, mMainP);
  end

  int refPulses = 0, mainPulses = 0;
  always @(posedge clk) if (rstN) begin
    if (refLoad) refPulses++;
    if (mainLoad) mainPulses++;
  end

  task automatic shiftBits(logic [17:0] word, logic sel);
    for (int i = 18; i >= 0; i--) begin
      @(negedge clk); serData = (i == 0) ? sel : word[i-1];
      repeat (3) @(negedge clk); serClk = 1;
      repeat (3) @(negedge clk); serClk = 0;
    end
    repeat (3) @(negedge clk);
  endtask

  task automatic strobe();
    @(negedge clk); serLe = 1;
    repeat (6) @(negedge clk); serLe = 0;
    repeat (6) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 refDiv", refDiv, 0);
    chk("R1 mainCnt", mainCnt, 0);
    chk("R1 swallowCnt", swallowCnt, 0);
    chk("R1 pulses", {refLoad, mainLoad}, 0);
    rstN = 1;
    repeat (4) @(negedge clk);

    // R3: upper four bits ignored; R2 MSB-first ordering
    shiftBits(18'h3_EA5F & 18'h3FFFF, 1'b1);
    strobe();
    chk("R3 R2 ref load", refDiv, 14'h2A5F);
    chk("R5 main untouched", {mainCnt, swallowCnt}, 0);
    chk("R7 one ref pulse", refPulses, 1);

    // R4: N=ABC, A=2D
    shiftBits({12'hABC, 6'h2D}, 1'b0);
    strobe();
    chk("R4 N", mainCnt, 12'hABC);
    chk("R4 A", swallowCnt, 6'h2D);
    chk("R5 ref untouched", refDiv, 14'h2A5F);
    chk("R7 one main pulse", mainPulses, 1);

    // R6: shifting without latch strobe
    shiftBits(18'h15555, 1'b1);
    chk("R6 ref held", refDiv, 14'h2A5F);
    chk("R6 main held", {mainCnt, swallowCnt}, {12'hABC, 6'h2D});
    chk("R6 no pulses", refPulses + mainPulses, 2);

    // R4 boundary: all ones, then minimum N
    shiftBits({12'hFFF, 6'h3F}, 1'b0);
    strobe();
    chk("R4 max N", mainCnt, 12'hFFF);
    chk("R4 max A", swallowCnt, 6'h3F);
    shiftBits({12'd5, 6'd0}, 1'b0);
    strobe();
    chk("R4 min N", mainCnt, 12'd5);
    chk("R4 zero A", swallowCnt, 6'd0);

    // R7: long strobe gives one pulse
    shiftBits(18'h3FFFF, 1'b1);
    @(negedge clk); serLe = 1;
    repeat (40) @(negedge clk);
    chk("R7 held strobe single pulse", refPulses, 2);
    chk("R3 all ones ref", refDiv, 14'h3FFF);
    serLe = 0;
    repeat (8) @(negedge clk);
    chk("R7 main pulse total", mainPulses, 3);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule